// File: doc/BRIEF.md
# Outgoing Channel Transaction Producer

This block sits on the accelerator side of a host streaming channel and turns a single start command into one outgoing transaction. When started from idle it captures a word count, a destination offset and an end-of-sequence flag. It then raises a transaction request and shows these three values to the channel framework. The framework answers with an acknowledge pulse at any point during the transaction. The block counts transfer size in 32-bit words. The offset says where in the host's receive buffer the first word should be placed.

Data comes from a local source through a valid/ready port. Each accepted word is placed in a single output holding register. The framework drains that register with its own read enable. Back-pressure works like this: the source is ready only while words remain to be fetched and the holding register is empty or being read in the same cycle. A word on the output stays put, unchanged, until the framework reads it. The request drops once the last word has been read. The block returns to idle only after it has both sent every word and seen the acknowledge. A busy output blocks new start commands until then.

Top module: `tx_txn_producer`

## Requirements
- R1: After reset, and whenever busy is low, `txn_req`, `tx_valid` and `busy` are low.
- R2: A start sampled high while idle makes `txn_req` and `busy` high from the next cycle, and `txn_len`, `txn_off` and `txn_last` show the captured `cfg_len`, `cfg_off` and `cfg_last`.
- R3: `txn_len`, `txn_off` and `txn_last` do not change while `txn_req` stays high.
- R4: `txn_req` stays high until the cycle after the final word is consumed; at the moment it drops, exactly `txn_len` words have been consumed, and `tx_valid` is never high without `txn_req`.
- R5: A word is consumed on a clock edge where `tx_valid` and `tx_ren` are both high; while `tx_valid` is high and `tx_ren` low, `tx_valid` and `tx_data` hold.
- R6: Consumed words appear in the order the source delivered them, and exactly `txn_len` of them appear.
- R7: `src_ready` is high only in the data phase with words left to fetch and the output register free or being read; no more than `txn_len` source words are taken.
- R8: The acknowledge may arrive at any cycle while busy, before, during or after the data; `busy` stays high until both the acknowledge has been seen and every word is consumed, then falls.
- R9: With a length of zero, the request is raised, `tx_valid` is never asserted, and the block waits for the acknowledge before leaving busy.
- R10: A start while busy is ignored: the presented fields and the word count of the running transaction are unchanged, and no second transaction follows.
- R11: An acknowledge pulse while idle is ignored and does not complete the next transaction early.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one transaction (taken only while idle) |
| cfg_len | input | LEN_W | Word count to send |
| cfg_off | input | OFF_W | Destination offset in 32-bit words |
| cfg_last | input | 1 | Final transaction of a sequence |
| busy | output | 1 | Transaction in progress |
| src_data | input | DATA_W | Local source word |
| src_valid | input | 1 | Local source word available |
| src_ready | output | 1 | Block accepts the source word this cycle |
| txn_req | output | 1 | Transaction request to the framework |
| txn_ack | input | 1 | Framework acknowledge pulse |
| txn_len | output | LEN_W | Presented word count |
| txn_off | output | OFF_W | Presented destination offset |
| txn_last | output | 1 | Presented end-of-sequence flag |
| tx_data | output | DATA_W | Word offered to the framework |
| tx_valid | output | 1 | `tx_data` holds a word |
| tx_ren | input | 1 | Framework read enable |

## Verification
The bound checker checks several rules on every cycle: idle quiet outputs, stable presented fields while the request is high, held data under a low read enable, data only while requesting, a source gate that never fills an occupied register, and no valid on a zero-length transaction. Other behaviour needs a whole scenario and only the bench's scenarios can show it: word order and count, the request dropping exactly after the final word, the busy release following a late acknowledge, and starts or idle acknowledges being ignored. The bench runs these scenarios under several patterns of read enable, source stalls and acknowledge placement.

// File: rtl/tx_prod_pkg.sv
package tx_prod_pkg;
  localparam int unsigned LEN_W_DEF = 32;
  localparam int unsigned OFF_W_DEF = 31;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_SEND = 2'd2,
    ST_DONE = 2'd3
  } txp_state_e;
endpackage

// File: rtl/txp_word_counter.sv
module txp_word_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] count,
  output logic         is_zero
);
  assign is_zero = (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (load) begin
      count <= load_val;
    end else if (dec && !is_zero) begin
      count <= count - W'(1);
    end
  end
endmodule

// File: rtl/txp_hold_stage.sv
module txp_hold_stage #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] in_data,
  input  logic          take,
  output logic [DW-1:0] out_data,
  output logic          out_valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (load) begin
        out_valid <= 1'b1;
        out_data  <= in_data;
      end else if (take) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/txp_ctrl.sv
module txp_ctrl
  import tx_prod_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       len_zero,
  input  logic       ack,
  input  logic       send_finish,
  output txp_state_e state,
  output logic       busy,
  output logic       req,
  output logic       accept
);
  txp_state_e nxt;
  logic       ack_seen;
  logic       ack_any;

  assign busy    = (state != ST_IDLE);
  assign req     = (state == ST_REQ) || (state == ST_SEND);
  assign accept  = (state == ST_IDLE) && start;
  assign ack_any = ack_seen || ack;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (start) nxt = ST_REQ;
      ST_REQ: begin
        if (!len_zero)    nxt = ST_SEND;
        else if (ack_any) nxt = ST_DONE;
      end
      ST_SEND: if (send_finish) nxt = ST_DONE;
      ST_DONE: if (ack_any) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      ack_seen <= 1'b0;
    end else begin
      state <= nxt;
      if (accept)                          ack_seen <= 1'b0;
      else if (ack && state != ST_IDLE)    ack_seen <= 1'b1;
    end
  end
endmodule

// File: rtl/tx_txn_producer.sv
module tx_txn_producer
  import tx_prod_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LEN_W  = LEN_W_DEF,
  parameter int unsigned OFF_W  = OFF_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [OFF_W-1:0]  cfg_off,
  input  logic              cfg_last,
  output logic              busy,
  input  logic [DATA_W-1:0] src_data,
  input  logic              src_valid,
  output logic              src_ready,
  output logic              txn_req,
  input  logic              txn_ack,
  output logic [LEN_W-1:0]  txn_len,
  output logic [OFF_W-1:0]  txn_off,
  output logic              txn_last,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_valid,
  input  logic              tx_ren
);
  localparam logic [LEN_W-1:0] ONE_WORD = LEN_W'(1);

  txp_state_e       state;
  logic             accept;
  logic             consume;
  logic             fetch;
  logic             send_finish;
  logic [LEN_W-1:0] fetch_left;
  logic             fetch_zero;
  logic [LEN_W-1:0] send_left;
  logic             send_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txn_len  <= '0;
      txn_off  <= '0;
      txn_last <= 1'b0;
    end else if (accept) begin
      txn_len  <= cfg_len;
      txn_off  <= cfg_off;
      txn_last <= cfg_last;
    end
  end

  txp_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .len_zero    (txn_len == '0),
    .ack         (txn_ack),
    .send_finish (send_finish),
    .state       (state),
    .busy        (busy),
    .req         (txn_req),
    .accept      (accept)
  );

  assign consume     = tx_valid && tx_ren;
  assign src_ready   = (state == ST_SEND) && !fetch_zero && (!tx_valid || tx_ren);
  assign fetch       = src_valid && src_ready;
  assign send_finish = consume && !send_zero && (send_left == ONE_WORD);

  txp_word_counter #(.W(LEN_W)) u_fetch_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (cfg_len),
    .dec      (fetch),
    .count    (fetch_left),
    .is_zero  (fetch_zero)
  );

  txp_word_counter #(.W(LEN_W)) u_send_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (cfg_len),
    .dec      (consume),
    .count    (send_left),
    .is_zero  (send_zero)
  );

  txp_hold_stage #(.DW(DATA_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (fetch),
    .in_data   (src_data),
    .take      (consume),
    .out_data  (tx_data),
    .out_valid (tx_valid)
  );
endmodule

// File: rtl/txp_checker.sv
module txp_checker #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LEN_W  = 32,
  parameter int unsigned OFF_W  = 31
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              txn_req,
  input logic [LEN_W-1:0]  txn_len,
  input logic [OFF_W-1:0]  txn_off,
  input logic              txn_last,
  input logic [DATA_W-1:0] tx_data,
  input logic              tx_valid,
  input logic              tx_ren,
  input logic              src_ready
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!txn_req && !tx_valid));

  // R3
  fields_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_req |=> (!txn_req || ($stable(txn_len) && $stable(txn_off) && $stable(txn_last))));

  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ren) |=> (tx_valid && $stable(tx_data)));

  // R4
  valid_in_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> txn_req);

  // R7
  src_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_ready && tx_valid) |-> tx_ren);

  // R9
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_req && txn_len == '0) |-> !tx_valid);

  // R8
  req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_req |-> busy);
endmodule

bind tx_txn_producer txp_checker #(
  .DATA_W(DATA_W), .LEN_W(LEN_W), .OFF_W(OFF_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .txn_req   (txn_req),
  .txn_len   (txn_len),
  .txn_off   (txn_off),
  .txn_last  (txn_last),
  .tx_data   (tx_data),
  .tx_valid  (tx_valid),
  .tx_ren    (tx_ren),
  .src_ready (src_ready)
);

// File: tb/sim_tx_txn_producer.sv
`timescale 1ns/1ps
module sim_tx_txn_producer;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [31:0]   cfg_len = '0;
  logic [30:0]   cfg_off = '0;
  logic          cfg_last = 1'b0;
  logic          busy;
  logic [DW-1:0] src_data = '0;
  logic          src_valid = 1'b0;
  logic          src_ready;
  logic          txn_req;
  logic          txn_ack = 1'b0;
  logic [31:0]   txn_len;
  logic [30:0]   txn_off;
  logic          txn_last;
  logic [DW-1:0] tx_data;
  logic          tx_valid;
  logic          tx_ren = 1'b0;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  tx_txn_producer u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_len(cfg_len), .cfg_off(cfg_off),
    .cfg_last(cfg_last), .busy(busy), .src_data(src_data), .src_valid(src_valid),
    .src_ready(src_ready), .txn_req(txn_req), .txn_ack(txn_ack), .txn_len(txn_len),
    .txn_off(txn_off), .txn_last(txn_last), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ren(tx_ren)
  );

  typedef struct packed {
    logic [15:0] len;
    logic [15:0] ack_at;
    logic [1:0]  ren_m;
    logic [1:0]  src_m;
    logic        last;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{16'd8,  16'd0,  2'd0, 2'd0, 1'b1},
    '{16'd5,  16'd2,  2'd1, 2'd0, 1'b0},
    '{16'd6,  16'd40, 2'd2, 2'd1, 1'b1},
    '{16'd0,  16'd4,  2'd0, 2'd0, 1'b1},
    '{16'd1,  16'd0,  2'd1, 2'd2, 1'b0},
    '{16'd12, 16'd9,  2'd0, 2'd2, 1'b1}
  };

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic pat(input logic [1:0] m, input int c);
    case (m)
      2'd0: return 1'b1;
      2'd1: return c[0];
      default: return (c % 3) != 0;
    endcase
  endfunction

  task automatic run_txn(input int len, input int off, input bit last, input int ack_at,
                         input logic [1:0] ren_m, input logic [1:0] src_m,
                         input int base, input int inj);
    int cyc = 0, words = 0, srcidx = 0, bad_data = 0, unstable = 0, zvalid = 0;
    int ack_cyc = -1, end_cyc = -1, drop_words = -1;
    bit prev_req = 1'b1;
    @(negedge clk);
    start = 1'b1; cfg_len = len; cfg_off = off; cfg_last = last;
    @(negedge clk);
    start = 1'b0;
    // R2: request and fields appear the cycle after start
    check(txn_req && busy && txn_len == len && txn_off == off && txn_last == last,
          "R2", {txn_req, busy}, 3);
    while (end_cyc < 0 && cyc < 3000) begin
      tx_ren    = pat(ren_m, cyc);
      src_valid = pat(src_m, cyc + 1);
      src_data  = base + srcidx;
      txn_ack   = (cyc == ack_at);
      if (txn_ack) ack_cyc = cyc;
      if (cyc == inj) begin
        start = 1'b1; cfg_len = len + 50; cfg_off = off + 3; cfg_last = ~last;
      end else begin
        start = 1'b0;
      end
      #1;
      if (!busy) begin
        end_cyc = cyc;
      end else begin
        if (txn_req && (txn_len != len || txn_off != off || txn_last != last)) unstable++;
        if (prev_req && !txn_req && drop_words < 0) drop_words = words;
        prev_req = txn_req;
        if (tx_valid && len == 0) zvalid++;
        if (tx_valid && tx_ren) begin
          if (tx_data != base + words) bad_data++;
          words++;
        end
        if (src_valid && src_ready) srcidx++;
        @(negedge clk);
        cyc++;
      end
    end
    txn_ack = 1'b0; tx_ren = 1'b0; src_valid = 1'b0; start = 1'b0;
    check(end_cyc >= 0, "R8 timeout", end_cyc, 0);
    check(words == len, "R6 count", words, len);
    check(bad_data == 0, "R6 order", bad_data, 0);
    check(srcidx == len, "R7 fetched", srcidx, len);
    check(unstable == 0, "R3", unstable, 0);
    check(drop_words == len, "R4", drop_words, len);
    check(ack_cyc >= 0 && ack_cyc < end_cyc, "R8 release", end_cyc, ack_cyc + 1);
    if (len == 0) check(zvalid == 0, "R9", zvalid, 0);
    @(negedge clk);
    check(!busy && !txn_req && !tx_valid, "R1 idle after", {busy, txn_req, tx_valid}, 0);
    if (inj >= 0) check(!busy && txn_len == len, "R10", txn_len, len);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy && !txn_req && !tx_valid && !src_ready, "R1 reset",
          {busy, txn_req, tx_valid, src_ready}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !txn_req, "R1 post reset", {busy, txn_req}, 0);

    for (int i = 0; i < 6; i++) begin
      run_txn(int'(VECS[i].len), i * 100 + 7, VECS[i].last, int'(VECS[i].ack_at),
              VECS[i].ren_m, VECS[i].src_m, 32'hA000_0000 + (i << 16), -1);
    end

    // R10: start pulses while busy are ignored
    run_txn(4, 55, 1'b0, 20, 2'd1, 2'd0, 32'h5500_0000, 3);

    // R11: acknowledge in idle must not finish the next transaction early
    @(negedge clk); txn_ack = 1'b1;
    @(negedge clk); txn_ack = 1'b0;
    check(!busy, "R11 idle ack", busy, 0);
    run_txn(3, 9, 1'b1, 30, 2'd0, 2'd0, 32'h7700_0000, -1);

    // R9: zero length with a late acknowledge
    run_txn(0, 1, 1'b0, 15, 2'd0, 2'd0, 32'h0, -1);

    // R5: consumer stalled with valid data held
    run_txn(3, 2, 1'b1, 1, 2'd2, 2'd2, 32'h3300_0000, -1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) cycles <= cycles + 1;
endmodule